// File: doc/BRIEF.md
# Auto-Turnaround Bidirectional Nibble Port

This block is a small I/O-mapped port for a 4-bit microcontroller bus. It has no direction register. The port turns around on its own, based on the most recent access to its data register. A write (OUT) stores a nibble in the output latches and drives every implemented pin. A read (IN) releases every pin and returns the sampled pin levels. Only nibble positions 0 and 3 are physical pins. Positions 1 and 2 do not exist.

The bus side decodes one port address. A select line picks between the data register (primary space) and a 4-bit scratch control register (auxiliary space). The control register has no effect on the direction. On the pin side, the block gives a pad wrapper an output value, a per-bit output enable and a pin input. Pin inputs pass through a two-flop synchronizer. Because of this, the first reads after an output phase return the level that was still being driven, which models the stale first read that follows a turnaround.

Top module: `auto_dir_port`

## Requirements
- R1: While reset is held and directly after it, pin_o is 4'b1001 (latches at 1 on bits 0 and 3), pin_oe_o is 4'b0000, the control register reads 0 and the synchronizer holds 0.
- R2: A write strobe with aux_i=0 and addr_i equal to PORT_ADDR sets pin_o to wdata_i & 4'b1001 and pin_oe_o to 4'b1001 in the first cycle after the strobe's clock edge.
- R3: Bits 1 and 2 of pin_o, pin_oe_o and of data-register read data are always 0, and write data on those bits has no effect.
- R4: A read strobe of the data register sets pin_oe_o to 4'b0000 from the next cycle and leaves the output latches unchanged.
- R5: Data-register read data appears on rdata_o in the same cycle as rd_i. It equals the pin_i level of two cycles earlier, ANDed with 4'b1001.
- R6: The reads in the two cycles after an IN that ends an output phase return the value that was being driven. A read three or more cycles after that IN returns the external level.
- R7: The control register (aux_i=1) is a 4-bit read/write register. Reads return its value in the same cycle, and writes take effect at the clock edge.
- R8: Control-register accesses leave pin_o and pin_oe_o unchanged.
- R9: When wr_i and rd_i both address the data register in one cycle, the write takes effect and the port ends in output mode.
- R10: Accesses to any address other than PORT_ADDR change nothing. rdata_o is 0 whenever no matching read is active.
- R11: In cycles without a data-register access, pin_o and pin_oe_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Port address |
| aux_i | input | 1 | 1 selects the control register, 0 selects the data register |
| wr_i | input | 1 | Write strobe (OUT) |
| rd_i | input | 1 | Read strobe (IN) |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data, valid in the strobe cycle |
| pin_o | output | 4 | Output level per pin |
| pin_oe_o | output | 4 | Output enable per pin |
| pin_i | input | 4 | Pad input level per pin |

## Verification
A wrong direction state shows up on pin_oe_o one cycle after the offending strobe. A corrupted output latch shows up on pin_o in that same cycle, whenever the port is driving. Errors in the synchronizer depth or the reset value only become visible on rdata_o, two cycles later than the pin change that exposes them. For that reason, the bench runs reads back to back across a turnaround and compares every cycle against a pin-history model. A control register that wrongly affects the direction shows up on the pins in the cycle after the auxiliary access.

// File: rtl/autodir_pkg.sv
package autodir_pkg;
  localparam int unsigned NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;
  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } dir_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

  // R5: output follows input exactly STAGES-deep (checked for default depth)
  if (STAGES == 2) begin : g_chk
    p_sync_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni, 2) |-> q_o == $past(d_i, 2));
  end
endmodule

// File: rtl/port_latch.sv
module port_latch
  import autodir_pkg::*;
#(
  parameter nib_t PIN_MASK = 4'b1001
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_stb_i,
  input  logic in_stb_i,
  input  nib_t wdata_i,
  output nib_t pin_o,
  output nib_t pin_oe_o
);
  nib_t dat_q;
  dir_e dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= PIN_MASK;
      dir_q <= DIR_IN;
    end else if (out_stb_i) begin
      dat_q <= wdata_i & PIN_MASK;
      dir_q <= DIR_OUT;
    end else if (in_stb_i) begin
      dir_q <= DIR_IN;
    end
  end

  assign pin_o    = dat_q;
  assign pin_oe_o = (dir_q == DIR_OUT) ? PIN_MASK : '0;

  p_out_drives_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_stb_i |=> (pin_oe_o == PIN_MASK) && (pin_o == ($past(wdata_i) & PIN_MASK)));
  p_in_releases_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_stb_i && !out_stb_i) |=> (pin_oe_o == '0) && $stable(pin_o));
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_stb_i && !out_stb_i) |=> $stable(pin_o) && $stable(pin_oe_o));
  p_no_phantom_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o | pin_oe_o) & ~PIN_MASK) == '0);
endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
  import autodir_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_stb_i,
  input  nib_t wdata_i,
  output nib_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (wr_stb_i) q_o <= wdata_i;
  end

  p_ctrl_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> q_o == $past(wdata_i));
endmodule

// File: rtl/auto_dir_port.sv
module auto_dir_port
  import autodir_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned PORT_ADDR   = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter nib_t        PIN_MASK    = 4'b1001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aux_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [3:0]        wdata_i,
  output logic [3:0]        rdata_o,
  output logic [3:0]        pin_o,
  output logic [3:0]        pin_oe_o,
  input  logic [3:0]        pin_i
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PORT_ADDR);

  logic addr_hit, dat_hit, aux_hit;
  logic out_stb, in_stb, ctrl_wr;
  nib_t pin_sync_q, ctrl_q;

  assign addr_hit = (addr_i == MY_ADDR);
  assign dat_hit  = addr_hit && !aux_i;
  assign aux_hit  = addr_hit && aux_i;
  assign out_stb  = wr_i && dat_hit;
  assign in_stb   = rd_i && dat_hit && !wr_i;  // write wins on collision
  assign ctrl_wr  = wr_i && aux_hit;

  pin_sync #(.W(NIB_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync_q)
  );

  port_latch #(.PIN_MASK(PIN_MASK)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .out_stb_i (out_stb),
    .in_stb_i  (in_stb),
    .wdata_i   (wdata_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o)
  );

  ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (ctrl_wr),
    .wdata_i  (wdata_i),
    .q_o      (ctrl_q)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i && aux_hit)      rdata_o = ctrl_q;
    else if (rd_i && dat_hit) rdata_o = pin_sync_q & PIN_MASK;
  end

  p_aux_no_dir_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_i && (wr_i || rd_i)) |=> $stable(pin_oe_o) && $stable(pin_o));
  p_collide_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && dat_hit) |=> pin_oe_o == PIN_MASK);
  p_miss_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_hit |-> rdata_o == '0);
  p_miss_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_hit |=> $stable(pin_oe_o) && $stable(pin_o));
endmodule

// File: tb/auto_dir_port_test.sv
module auto_dir_port_test;
  localparam logic [3:0] MASK = 4'b1001;
  localparam logic [3:0] PADR = 4'd1;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr = '0;
  logic       aux = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [3:0] wdata = '0, ext = '0;
  logic [3:0] rdata, pin_o, pin_oe, pin_i;

  int n_chk = 0, n_fail = 0;

  logic [3:0] m_dat = MASK, m_oe = '0, m_ctrl = '0;
  logic [3:0] hist[$];

  always #10 clk = ~clk;

  // pad model: driven bits loop back, released bits follow the external level
  assign pin_i = (pin_oe & pin_o) | (~pin_oe & ext);

  auto_dir_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .aux_i(aux),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .pin_o(pin_o), .pin_oe_o(pin_oe), .pin_i(pin_i)
  );

  task automatic chk(string tag, string what, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic step(string tag, logic w, logic r, logic a, logic [3:0] ad,
                      logic [3:0] wd, logic [3:0] ex);
    logic [3:0] exp_rd, smp;
    wr = w; rd = r; aux = a; addr = ad; wdata = wd; ext = ex;
    #1;
    exp_rd = '0;
    if (r && ad == PADR) exp_rd = a ? m_ctrl : (hist[hist.size()-2] & MASK);
    chk(tag, "rdata", rdata, exp_rd);
    chk(tag, "pin_o", pin_o, m_dat);
    chk(tag, "pin_oe", pin_oe, m_oe);
    smp = (m_oe & m_dat) | (~m_oe & ex);
    @(posedge clk);
    hist.push_back(smp);
    if (ad == PADR && !a) begin
      if (w) begin m_dat = wd & MASK; m_oe = MASK; end
      else if (r) m_oe = '0;
    end
    if (ad == PADR && a && w) m_ctrl = wd;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic idle(string tag, logic [3:0] ex);
    step(tag, 1'b0, 1'b0, 1'b0, PADR, 4'h0, ex);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    hist.push_back(4'h0);
    hist.push_back(4'h0);
    repeat (3) @(negedge clk);
    chk("R1", "pin_o in reset", pin_o, MASK);
    chk("R1", "pin_oe in reset", pin_oe, 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: control register and synchronizer start at 0
    step("R1", 1'b0, 1'b1, 1'b1, PADR, 4'h0, 4'h0);
    step("R1", 1'b0, 1'b1, 1'b0, PADR, 4'h0, 4'h0);
    // R2/R3: OUT drives, phantom bits dropped
    step("R3", 1'b1, 1'b0, 1'b0, PADR, 4'b0110, 4'h0);
    step("R2", 1'b1, 1'b0, 1'b0, PADR, 4'b1111, 4'h0);
    step("R2", 1'b1, 1'b0, 1'b0, PADR, 4'b1000, 4'b0111);
    idle("R11", 4'b0111);
    idle("R11", 4'b0111);
    // R4/R6: turnaround; the first reads see the driven value
    step("R6", 1'b0, 1'b1, 1'b0, PADR, 4'h0, 4'b0111);
    step("R6", 1'b0, 1'b1, 1'b0, PADR, 4'h0, 4'b0111);
    step("R4", 1'b0, 1'b1, 1'b0, PADR, 4'h0, 4'b0111);
    step("R6", 1'b0, 1'b1, 1'b0, PADR, 4'h0, 4'b0111);
    // R5: input mode follows external changes two cycles late
    step("R5", 1'b0, 1'b1, 1'b0, PADR, 4'h0, 4'b1000);
    step("R5", 1'b0, 1'b1, 1'b0, PADR, 4'h0, 4'b1110);
    step("R5", 1'b0, 1'b1, 1'b0, PADR, 4'h0, 4'b1110);
    step("R5", 1'b0, 1'b1, 1'b0, PADR, 4'h0, 4'b1110);
    step("R5", 1'b0, 1'b1, 1'b0, PADR, 4'h0, 4'b1110);
    // R7/R8: control register, no effect on direction
    step("R7", 1'b1, 1'b0, 1'b1, PADR, 4'b1010, 4'b1110);
    step("R7", 1'b0, 1'b1, 1'b1, PADR, 4'h0, 4'b1110);
    step("R8", 1'b0, 1'b0, 1'b0, PADR, 4'h0, 4'b1110);
    step("R2", 1'b1, 1'b0, 1'b0, PADR, 4'b0001, 4'b0000);
    step("R8", 1'b1, 1'b0, 1'b1, PADR, 4'b0101, 4'b0000);
    step("R8", 1'b0, 1'b1, 1'b1, PADR, 4'h0, 4'b0000);
    idle("R8", 4'b0000);
    // R9: collision, write wins
    step("R4", 1'b0, 1'b1, 1'b0, PADR, 4'h0, 4'b1001);
    step("R9", 1'b1, 1'b1, 1'b0, PADR, 4'b1001, 4'b0000);
    idle("R9", 4'b0000);
    // R10: foreign address
    step("R10", 1'b1, 1'b0, 1'b0, 4'd2, 4'b0000, 4'b0000);
    step("R10", 1'b0, 1'b1, 1'b0, 4'd2, 4'h0, 4'b0000);
    step("R10", 1'b1, 1'b0, 1'b1, 4'd7, 4'b1111, 4'b0000);
    step("R10", 1'b0, 1'b1, 1'b1, PADR, 4'h0, 4'b0000);
    idle("R11", 4'b0000);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule